// File: doc/BRIEF.md
# Three-Phase Center-Aligned Complementary PWM

This block drives three inverter legs from one shared triangular carrier. A counter climbs from zero to a programmed peak and falls back to zero, once per carrier period. Each leg holds a compare value. A match on the rising slope sets the leg's switching flip-flop, and a match on the falling slope clears it. This gives a pulse centred on the peak of the carrier.

A dead-band stage sits after each flip-flop. It produces a high-side pin and a low-side pin for the leg. After every change of the flip-flop it holds both pins off for a programmed number of cycles. A polarity bit selects active-high or active-low pins. Two single-cycle interrupt pulses mark the peak and the return to zero.

Software updates the peak and the compare values through buffer registers. These values take effect only at the carrier zero, so every period runs on one consistent set of values. A compare value above the peak keeps the leg switched off for whole periods. This lets the leg produce pulse widths longer than one carrier cycle.

Top module: `tri_pwm3`

## Requirements
- R1: The counter steps by exactly one each cycle. It starts at 0, climbs to the active peak, then falls back to 0. Consecutive zero pulses are therefore exactly 2 x peak cycles apart.
- R2: `irq_peak_o` is high for the single cycle in which the counter holds the peak. `irq_zero_o` is high for the single cycle in which the counter is back at 0 after falling. The two are never high together, and there is exactly one peak pulse per period.
- R3: A write with `wr_en` high lands in a buffer register chosen by `wr_sel`: 0 peak, 1 dead-time count, 2 polarity (bit 0), 3+i compare value of leg i. The peak and compare buffers move to the active registers only on the cycle in which the counter enters 0. A value written mid-period leaves the current period unchanged.
- R4: For a compare value C below the peak P, the leg's flip-flop is set on the rising-slope match and cleared on the falling-slope match. With dead-time count D, the high-side pin is therefore active for 2(P-C)-(D+1) cycles per period.
- R5: After every change of a leg's flip-flop, both pins of that leg are inactive for D+1 cycles. Here D is the dead-time register value when the change happens.
- R6: A compare value above the peak clears the flip-flop. The high-side pin stays inactive and the low-side pin stays active for the whole period.
- R7: A compare value equal to the peak matches only as a clearing event. The flip-flop is never set, and the high-side pin never becomes active.
- R8: Polarity bit 1 inverts both pins of every leg from the cycle after the write. Nothing else changes.
- R9: While reset is asserted, all six pins and both interrupts are low. The counter starts at 0 counting up, so the first peak pulse arrives after exactly peak-reset-value cycles.
- R10: If a flip-flop changes again before its dead time has run out, the dead-time count restarts. The pin that was pending stays inactive.
- R11: The high-side and low-side pins of one leg are never active in the same cycle.
- R12: A peak value of 0 is used as 1, which gives a 2-cycle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select for the write |
| wr_data | input | CNT_W | Write data |
| pos_o | output | NPH | High-side pin of each leg |
| neg_o | output | NPH | Low-side pin of each leg |
| irq_peak_o | output | 1 | One-cycle pulse at the carrier peak |
| irq_zero_o | output | 1 | One-cycle pulse at the carrier zero |

## Verification
The three legs are loaded at once with compare values below the peak, equal to it and above it. One period then shows the normal centred pulse, the set-never-happens case and the pinned-off case side by side. A compare value one below the peak, combined with a long dead time, makes the flip-flop toggle twice inside the dead band. This separates a restarting dead-time counter from one that only loads on the first edge. Further cases cover a compare write made at the peak, which separates buffered loading from immediate loading, a polarity flip, and a peak of zero. Seeded random sets of peak, compare, dead time and polarity are then checked cycle by cycle against a bench model.

// File: rtl/tri_pwm3_pkg.sv
package tri_pwm3_pkg;
    localparam int unsigned SEL_W = 4;

    // Write-port register select; leg i uses SEL_CMP + i
    typedef enum logic [SEL_W-1:0] {
        SEL_PEAK = 4'd0,
        SEL_DEAD = 4'd1,
        SEL_POL  = 4'd2,
        SEL_CMP  = 4'd3
    } sel_e;
endpackage

// File: rtl/tri_pwm3_regs.sv
module tri_pwm3_regs
    import tri_pwm3_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DT_W     = 8,
    parameter int NPH      = 3,
    parameter int PEAK_RST = 255
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [CNT_W-1:0]              wr_data,
    output logic [CNT_W-1:0]              peak_buf_o,
    output logic [NPH-1:0][CNT_W-1:0]     cmp_buf_o,
    output logic [DT_W-1:0]               dead_o,
    output logic                          pol_o
);
    typedef struct packed {
        logic [CNT_W-1:0]          peak;
        logic [NPH-1:0][CNT_W-1:0] cmp;
        logic [DT_W-1:0]           dead;
        logic                      pol;
    } regs_t;

    localparam regs_t RST_VAL = '{
        peak: CNT_W'(PEAK_RST),
        cmp:  {NPH*CNT_W{1'b1}},
        dead: '0,
        pol:  1'b0
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_sel == SEL_PEAK) r_d.peak = wr_data;
            if (wr_sel == SEL_DEAD) r_d.dead = wr_data[DT_W-1:0];
            if (wr_sel == SEL_POL)  r_d.pol  = wr_data[0];
            for (int i = 0; i < NPH; i++) begin
                if (wr_sel == SEL_W'(int'(SEL_CMP) + i)) r_d.cmp[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= RST_VAL;
        else        r_q <= r_d;
    end

    assign peak_buf_o = r_q.peak;
    assign cmp_buf_o  = r_q.cmp;
    assign dead_o     = r_q.dead;
    assign pol_o      = r_q.pol;
endmodule

// File: rtl/tri_pwm3_carrier.sv
module tri_pwm3_carrier #(
    parameter int CNT_W    = 16,
    parameter int PEAK_RST = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] peak_buf,
    output logic [CNT_W-1:0] cnt_o,
    output logic             up_o,
    output logic [CNT_W-1:0] peak_o,
    output logic             reload_o,
    output logic             irq_peak_o,
    output logic             irq_zero_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             up;
        logic [CNT_W-1:0] peak;
    } car_t;

    localparam car_t RST_VAL = '{cnt: '0, up: 1'b1, peak: CNT_W'(PEAK_RST)};

    car_t c_d, c_q;
    logic reload;

    always_comb begin
        c_d = c_q;
        if (c_q.up) begin
            if (c_q.cnt >= c_q.peak) begin
                c_d.up  = 1'b0;
                c_d.cnt = c_q.cnt - 1'b1;
            end else begin
                c_d.cnt = c_q.cnt + 1'b1;
            end
        end else if (c_q.cnt == '0) begin
            c_d.up  = 1'b1;
            c_d.cnt = CNT_W'(1);
        end else begin
            c_d.cnt = c_q.cnt - 1'b1;
        end
        // Shadow update on the edge that brings the counter to zero
        reload = (c_d.cnt == '0);
        if (reload) c_d.peak = (peak_buf == '0) ? CNT_W'(1) : peak_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= RST_VAL;
        else        c_q <= c_d;
    end

    assign cnt_o      = c_q.cnt;
    assign up_o       = c_q.up;
    assign peak_o     = c_q.peak;
    assign reload_o   = reload;
    assign irq_peak_o = c_q.up && (c_q.cnt == c_q.peak);
    assign irq_zero_o = !c_q.up && (c_q.cnt == '0);
endmodule

// File: rtl/tri_pwm3_phase.sv
module tri_pwm3_phase #(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             up,
    input  logic [CNT_W-1:0] peak,
    input  logic             reload,
    input  logic [CNT_W-1:0] cmp_buf,
    input  logic [DT_W-1:0]  dead,
    input  logic             pol,
    output logic             pos_o,
    output logic             neg_o,
    output logic             ff_o,
    output logic [CNT_W-1:0] cmp_o
);
    localparam int DTC_W = DT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             ff;
        logic [DTC_W-1:0] dtc;
    } ph_t;

    localparam ph_t RST_VAL = '{cmp: {CNT_W{1'b1}}, ff: 1'b0, dtc: DTC_W'(1)};

    ph_t  p_d, p_q;
    logic hit, set_m, clr_m, settled;

    always_comb begin
        p_d   = p_q;
        hit   = (cnt == p_q.cmp);
        set_m = hit && (p_q.cmp < peak) && (up || cnt == '0);
        clr_m = (p_q.cmp > peak) || (hit && cnt != '0 && (!up || cnt == peak));
        if (set_m)      p_d.ff = 1'b1;
        else if (clr_m) p_d.ff = 1'b0;
        if (p_d.ff != p_q.ff)      p_d.dtc = {1'b0, dead} + 1'b1;
        else if (p_q.dtc != '0)    p_d.dtc = p_q.dtc - 1'b1;
        if (reload) p_d.cmp = cmp_buf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= RST_VAL;
        else        p_q <= p_d;
    end

    assign settled = (p_q.dtc == '0);
    assign pos_o   = (p_q.ff & settled) ^ pol;
    assign neg_o   = (~p_q.ff & settled) ^ pol;
    assign ff_o    = p_q.ff;
    assign cmp_o   = p_q.cmp;
endmodule

// File: rtl/tri_pwm3.sv
module tri_pwm3
    import tri_pwm3_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int DT_W     = 8,
    parameter int NPH      = 3,
    parameter int PEAK_RST = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [NPH-1:0]   pos_o,
    output logic [NPH-1:0]   neg_o,
    output logic             irq_peak_o,
    output logic             irq_zero_o
);
    logic [CNT_W-1:0]          peak_buf, peak_act, cnt;
    logic [NPH-1:0][CNT_W-1:0] cmp_buf, cmp_act;
    logic [DT_W-1:0]           dead;
    logic                      pol, up, reload;
    logic [NPH-1:0]            ff_act;

    tri_pwm3_regs #(
        .CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH), .PEAK_RST(PEAK_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .peak_buf_o(peak_buf), .cmp_buf_o(cmp_buf), .dead_o(dead), .pol_o(pol)
    );

    tri_pwm3_carrier #(
        .CNT_W(CNT_W), .PEAK_RST(PEAK_RST)
    ) u_car (
        .clk(clk), .rst_n(rst_n), .peak_buf(peak_buf),
        .cnt_o(cnt), .up_o(up), .peak_o(peak_act), .reload_o(reload),
        .irq_peak_o(irq_peak_o), .irq_zero_o(irq_zero_o)
    );

    for (genvar g = 0; g < NPH; g++) begin : g_leg
        tri_pwm3_phase #(
            .CNT_W(CNT_W), .DT_W(DT_W)
        ) u_ph (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .up(up), .peak(peak_act),
            .reload(reload), .cmp_buf(cmp_buf[g]), .dead(dead), .pol(pol),
            .pos_o(pos_o[g]), .neg_o(neg_o[g]), .ff_o(ff_act[g]), .cmp_o(cmp_act[g])
        );
    end
endmodule

// File: rtl/tri_pwm3_chk.sv
module tri_pwm3_chk #(
    parameter int CNT_W = 16,
    parameter int NPH   = 3
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [CNT_W-1:0]          cnt,
    input logic                      up,
    input logic [CNT_W-1:0]          peak,
    input logic                      irq_peak,
    input logic                      irq_zero,
    input logic [NPH-1:0]            pos,
    input logic [NPH-1:0]            neg,
    input logic                      pol,
    input logic [NPH-1:0]            ff,
    input logic [NPH-1:0][CNT_W-1:0] cmp
);
    logic [NPH-1:0] pos_n, neg_n;
    assign pos_n = pos ^ {NPH{pol}};
    assign neg_n = neg ^ {NPH{pol}};

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= peak);                                                  // R1
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (cnt == $past(cnt) + 1 || cnt == $past(cnt) - 1)); // R1
    AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_peak && irq_zero));                                      // R2
    AST_PEAK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_peak |=> !irq_peak);                                       // R2
    AST_NO_SHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_n & neg_n) == '0);                                        // R11

    for (genvar i = 0; i < NPH; i++) begin : g_leg_chk
        AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (ff[i] != $past(ff[i])) |-> (!pos_n[i] && !neg_n[i]));      // R5
        AST_HIGH_CMP: assert property (@(posedge clk) disable iff (!rst_n)
            (cmp[i] > peak) |=> !pos_n[i]);                            // R6
    end
endmodule

bind tri_pwm3 tri_pwm3_chk #(.CNT_W(CNT_W), .NPH(NPH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .up(up), .peak(peak_act),
    .irq_peak(irq_peak_o), .irq_zero(irq_zero_o), .pos(pos_o), .neg(neg_o),
    .pol(pol), .ff(ff_act), .cmp(cmp_act)
);

// File: tb/tri_pwm3_test.sv
module tri_pwm3_test;
    localparam int CLK_P    = 10;
    localparam int CNT_W    = 16;
    localparam int DT_W     = 8;
    localparam int NPH      = 3;
    localparam int PEAK_RST = 255;
    localparam int WD_LIMIT = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [3:0]       wr_sel = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [NPH-1:0]   pos_o, neg_o;
    logic             irq_peak_o, irq_zero_o;

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    tri_pwm3 #(.CNT_W(CNT_W), .DT_W(DT_W), .NPH(NPH), .PEAK_RST(PEAK_RST)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pos_o(pos_o), .neg_o(neg_o), .irq_peak_o(irq_peak_o), .irq_zero_o(irq_zero_o)
    );

    // ---------------- reference model built from the requirements ----------------
    int m_cnt, m_pk, b_pk, b_dt;
    int m_cmp[NPH], m_dtc[NPH], b_cmp[NPH];
    bit m_up, b_pol;
    bit m_ff[NPH];

    function automatic void model_init();
        m_cnt = 0; m_up = 1'b1; m_pk = PEAK_RST; b_pk = PEAK_RST; b_dt = 0; b_pol = 1'b0;
        for (int i = 0; i < NPH; i++) begin
            m_cmp[i] = 65535; b_cmp[i] = 65535; m_ff[i] = 1'b0; m_dtc[i] = 1;
        end
    endfunction

    function automatic void model_step();
        int  n_cnt;
        bit  n_up, up_m, dn_m, n_ff;
        if (m_up) begin
            if (m_cnt >= m_pk) begin n_up = 1'b0; n_cnt = m_cnt - 1; end
            else               begin n_up = 1'b1; n_cnt = m_cnt + 1; end
        end else if (m_cnt == 0) begin
            n_up = 1'b1; n_cnt = 1;
        end else begin
            n_up = 1'b0; n_cnt = m_cnt - 1;
        end
        for (int i = 0; i < NPH; i++) begin
            up_m = (m_cnt == m_cmp[i]) && (m_cmp[i] < m_pk) && (m_up || m_cnt == 0);
            dn_m = (m_cmp[i] > m_pk) ||
                   ((m_cnt == m_cmp[i]) && m_cnt != 0 && (!m_up || m_cnt == m_pk));
            n_ff = up_m ? 1'b1 : (dn_m ? 1'b0 : m_ff[i]);
            if (n_ff != m_ff[i]) m_dtc[i] = b_dt + 1;
            else if (m_dtc[i] > 0) m_dtc[i] = m_dtc[i] - 1;
            m_ff[i] = n_ff;
            if (n_cnt == 0) m_cmp[i] = b_cmp[i];
        end
        if (n_cnt == 0) m_pk = (b_pk == 0) ? 1 : b_pk;
        m_cnt = n_cnt; m_up = n_up;
        if (wr_en) begin
            case (int'(wr_sel))
                0: b_pk = int'(wr_data);
                1: b_dt = int'(wr_data[DT_W-1:0]);
                2: b_pol = wr_data[0];
                default: if (int'(wr_sel) - 3 < NPH) b_cmp[int'(wr_sel) - 3] = int'(wr_data);
            endcase
        end
    endfunction

    function automatic int exp_pos();
        int v = 0;
        for (int i = 0; i < NPH; i++)
            if ((m_ff[i] && m_dtc[i] == 0) ^ b_pol) v |= (1 << i);
        return v;
    endfunction

    function automatic int exp_neg();
        int v = 0;
        for (int i = 0; i < NPH; i++)
            if ((!m_ff[i] && m_dtc[i] == 0) ^ b_pol) v |= (1 << i);
        return v;
    endfunction

    function automatic int exp_irq();
        return ((m_up && m_cnt == m_pk) ? 2 : 0) + ((!m_up && m_cnt == 0) ? 1 : 0);
    endfunction

    initial model_init();

    always @(posedge clk) begin
        if (!rst_n) model_init();
        else        model_step();
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (!done) begin
            chk("R4 R5 high-side pins vs model", int'(pos_o), exp_pos());
            chk("R5 R6 low-side pins vs model", int'(neg_o), exp_neg());
            chk("R2 interrupt pulses vs model", int'({irq_peak_o, irq_zero_o}), exp_irq());
            if (cyc > WD_LIMIT) begin
                errors++;
                $display("FAIL watchdog R1 carrier stalled actual %0d expected %0d", cyc, WD_LIMIT);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    int w_len, w_peaks;
    int w_pos[NPH], w_neg[NPH];

    task automatic wr(input int sel, input int data);
        wr_en = 1'b1; wr_sel = sel[3:0]; wr_data = data[CNT_W-1:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_zero();
        while (!irq_zero_o) @(negedge clk);
    endtask

    task automatic wait_peak();
        while (!irq_peak_o) @(negedge clk);
    endtask

    // From a zero sample, count one full period up to the next zero sample
    task automatic measure();
        w_len = 0; w_peaks = 0;
        for (int i = 0; i < NPH; i++) begin w_pos[i] = 0; w_neg[i] = 0; end
        do begin
            w_len++;
            if (irq_peak_o) w_peaks++;
            for (int i = 0; i < NPH; i++) begin
                if (pos_o[i]) w_pos[i]++;
                if (neg_o[i]) w_neg[i]++;
            end
            @(negedge clk);
        end while (!irq_zero_o);
    endtask

    initial begin
        int n, p;
        void'($urandom(32'd7351));
        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 pins in reset (high side)", int'(pos_o), 0);
        chk("R9 pins in reset (low side)", int'(neg_o), 0);
        chk("R9 interrupts in reset", int'({irq_peak_o, irq_zero_o}), 0);
        rst_n = 1'b1;
        n = 0;
        while (!irq_peak_o) begin
            @(negedge clk);
            n++;
        end
        chk("R9 first peak after reset", n, PEAK_RST);

        // Below / equal / above peak in one period
        wr(0, 20); wr(1, 2); wr(3, 5); wr(4, 20); wr(5, 30);
        wait_zero(); measure(); measure();
        chk("R1 period length", w_len, 40);
        chk("R2 one peak pulse per period", w_peaks, 1);
        chk("R4 high-side width leg0", w_pos[0], 27);
        chk("R5 low-side width leg0", w_neg[0], 7);
        chk("R7 compare equal peak high side", w_pos[1], 0);
        chk("R7 compare equal peak low side", w_neg[1], 40);
        chk("R6 compare above peak high side", w_pos[2], 0);
        chk("R6 compare above peak low side", w_neg[2], 40);

        // R8 polarity
        wr(2, 1);
        chk("R8 inverted high side", int'(pos_o), 7);
        chk("R8 inverted low side", int'(neg_o), 0);
        wr(2, 0);

        // R3 buffered compare written at the peak
        wait_peak();
        wr(3, 10);
        n = 0;
        do begin
            if (pos_o[0]) n++;
            @(negedge clk);
        end while (!irq_zero_o);
        chk("R3 old compare kept until zero", n, 15);
        measure();
        chk("R3 new compare after zero", w_pos[0], 17);

        // R10 second toggle inside the dead band
        wr(1, 4); wr(3, 19);
        wait_zero(); measure(); measure();
        chk("R10 pending high side suppressed", w_pos[0], 0);
        chk("R10 low side after restarted dead time", w_neg[0], 33);

        // R12 peak written as zero
        wr(0, 0);
        wait_zero(); measure(); measure();
        chk("R12 period with zero peak", w_len, 2);
        chk("R12 peak pulses", w_peaks, 1);

        // Random sets, model-checked every cycle
        for (int r = 0; r < 8; r++) begin
            p = 4 + int'($urandom % 37);
            wr(0, p);
            for (int i = 0; i < NPH; i++) wr(3 + i, int'($urandom % (p + 4)));
            wr(1, int'($urandom % 7));
            wr(2, int'($urandom % 2));
            wait_zero(); measure(); measure();
            chk("R1 random period length", w_len, 2 * p);
            chk("R2 random peak pulses", w_peaks, 1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule